// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block produces the internal CPU clock level of a small microcontroller from two oscillator sources: a fast main oscillator and a slow sub-oscillator. Both are presented as single-cycle tick enables on one system clock. The internal clock flips on every tick of the selected source, so it runs at half that source's rate. Software picks the source, can switch off the main oscillator while running from the sub-clock, and sets the drive strength of the sub-oscillator. All three settings sit in a three-bit control register.

Two strobes park the internal clock at logic high. The wait strobe keeps the oscillators running, and the clock restarts at once when a qualifying interrupt is accepted. The stop strobe also shuts the main oscillator down. After a qualifying interrupt wakes it, a two-stage chained down-counter behind a divide-by-16 prescaler must count out the oscillator start-up time before the clock is released. Reset releases either halt.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `cpu_clk` is 1, `clk_held` is 0, `src_sub` is 0, `main_osc_en` is 1 and `sub_drive_strong` is 1. The control register resets to 3'b001.
- R2: In normal mode, `cpu_clk` inverts once per `main_tick`, which gives half the main rate. `sub_tick` has no effect.
- R3: Control bit [2] set to 1 selects the sub-clock. `cpu_clk` then inverts once per `sub_tick`, and `main_tick` has no effect. `src_sub` follows bit [2] only in a cycle where `cpu_clk` is already high and does not toggle, so the switch never happens while the clock is low.
- R4: Control bit [1] set to 1 drives `main_osc_en` to 0, and main ticks are then discarded.
- R5: `sub_drive_strong` equals control bit [0]. Writing 0 selects weak drive.
- R6: One cycle after `stop_req`, `cpu_clk` is 1, `clk_held` is 1 and `main_osc_en` is 0. The block stays that way under oscillator ticks and under accepted interrupts flagged `irq_clkdep`.
- R7: After an accepted interrupt with `irq_clkdep`=0 ends stop mode, `main_osc_en` returns to 1. The clock stays held for exactly 32768 ticks of the selected source: a prescaler of 16, a stage-1 counter preset to 255 and a stage-2 counter preset to 7, where a stage-1 underflow decrements stage 2. `clk_held` falls in the cycle after the 32768th tick.
- R8: One cycle after `wait_req`, `cpu_clk` and `clk_held` are 1 and `main_osc_en` keeps its value. Ticks and interrupts flagged `irq_clkdep` leave the block held. An accepted interrupt with `irq_clkdep`=0 clears `clk_held` one cycle later, and the next tick toggles the clock.
- R9: When `stop_req` and `wait_req` arrive in the same cycle, stop mode is entered.
- R10: Reset releases both wait mode and stop mode and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | One-cycle tick per main oscillator period |
| sub_tick | input | 1 | One-cycle tick per sub-oscillator period |
| ctrl_wr | input | 1 | Control register write strobe (accepted while running) |
| ctrl_wdata | input | 3 | [2] sub-clock select, [1] main oscillator off, [0] strong sub drive |
| stop_req | input | 1 | Enter stop mode |
| wait_req | input | 1 | Enter wait mode |
| irq_accept | input | 1 | An interrupt was accepted this cycle |
| irq_clkdep | input | 1 | The accepted interrupt depends on the internal or a divided clock |
| cpu_clk | output | 1 | Internal clock level |
| clk_held | output | 1 | Internal clock parked high (wait, stop or stabilization) |
| src_sub | output | 1 | Sub-clock is the active source |
| main_osc_en | output | 1 | Main oscillator run enable |
| sub_drive_strong | output | 1 | Sub-oscillator drive strength select |

## Verification
The hardest case to reach is the end of stabilization. The interesting tick is the 32768th after the wake event, with a full prescaler and two counter stages chained behind it. The bench enters stop mode, applies ticks and clock-dependent interrupts to show that nothing advances, then wakes the block with a qualifying interrupt. It then feeds one main tick per cycle and confirms that the clock is still held after 32767 ticks and free after 32768. The source switch that is deferred while the clock is low is reached by writing the control register right after a sub-clock tick has driven the clock low.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
   typedef enum logic [1:0] {
      CM_RUN  = 2'd0,
      CM_WAIT = 2'd1,
      CM_STOP = 2'd2,
      CM_STAB = 2'd3
   } cm_state_t;

   localparam int CTRL_W    = 3;
   localparam int SEL_BIT   = 2;
   localparam int MOFF_BIT  = 1;
   localparam int DRV_BIT   = 0;
   localparam logic [CTRL_W-1:0] CTRL_RST = 3'b001;
endpackage

// File: rtl/cmc_ctrl_reg.sv
module cmc_ctrl_reg #(
   parameter int W = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("cmc_ctrl_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= wdata;
   end
endmodule

// File: rtl/cmc_stab_timer.sv
module cmc_stab_timer #(
   parameter int PRE_W   = 4,
   parameter int S1_W    = 8,
   parameter int S2_W    = 3,
   parameter int S1_INIT = 255,
   parameter int S2_INIT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam logic [S1_W-1:0] S1_PRE = S1_W'(S1_INIT);
   localparam logic [S2_W-1:0] S2_PRE = S2_W'(S2_INIT);

   generate
      if (S1_W < 1 || S2_W < 1 || PRE_W < 0) begin : g_bad_w
         $error("cmc_stab_timer: illegal widths");
      end
      if (S1_INIT >= (1 << S1_W) || S2_INIT >= (1 << S2_W)) begin : g_bad_init
         $error("cmc_stab_timer: preset does not fit its stage");
      end
   endgenerate

   logic            pre_wrap;
   logic [S1_W-1:0] s1_q;
   logic [S2_W-1:0] s2_q;
   logic            s1_zero;
   logic            s2_zero;

   generate
      if (PRE_W > 0) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           pre_q <= '0;
            else if (load)        pre_q <= '0;
            else if (run && tick) pre_q <= pre_q + 1'b1;
         end
         assign pre_wrap = run && tick && (pre_q == {PRE_W{1'b1}});
      end else begin : g_nopre
         assign pre_wrap = run && tick;
      end
   endgenerate

   assign s1_zero = (s1_q == '0);
   assign s2_zero = (s2_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         s1_q <= S1_PRE;
         s2_q <= S2_PRE;
      end else if (pre_wrap) begin
         s1_q <= s1_q - 1'b1;
         if (s1_zero) s2_q <= s2_q - 1'b1;
      end
   end

   assign done = pre_wrap && s1_zero && s2_zero;

   AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(s2_q) && !$past(load)) |-> ($past(s1_q) == '0)); // R7
endmodule

// File: rtl/cmc_phase_gen.sv
module cmc_phase_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic main_tk,
   input  logic sub_tk,
   input  logic want_sub,
   input  logic hold,
   input  logic force_high,
   output logic phi,
   output logic sel_sub,
   output logic src_tick
);
   logic toggle;

   assign src_tick = sel_sub ? sub_tk : main_tk;
   assign toggle   = src_tick && !hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phi     <= 1'b1;
         sel_sub <= 1'b0;
      end else begin
         if (force_high)  phi <= 1'b1;
         else if (toggle) phi <= ~phi;
         if (phi && !toggle && !force_high) sel_sub <= want_sub;
      end
   end

   AST_SWITCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_sub) |-> $past(phi)); // R3
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
   import clk_mode_pkg::*;
#(
   parameter int PRE_W   = 4,
   parameter int S1_W    = 8,
   parameter int S2_W    = 3,
   parameter int S1_INIT = 255,
   parameter int S2_INIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_tick,
   input  logic              sub_tick,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              stop_req,
   input  logic              wait_req,
   input  logic              irq_accept,
   input  logic              irq_clkdep,
   output logic              cpu_clk,
   output logic              clk_held,
   output logic              src_sub,
   output logic              main_osc_en,
   output logic              sub_drive_strong
);
   cm_state_t         state_q, state_d;
   logic [CTRL_W-1:0] ctrl_q;
   logic              running;
   logic              wake;
   logic              main_tk;
   logic              src_tick;
   logic              stab_done;

   assign running = (state_q == CM_RUN);
   assign wake    = irq_accept && !irq_clkdep;

   cmc_ctrl_reg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctrl_wr && running),
      .wdata (ctrl_wdata),
      .q     (ctrl_q)
   );

   assign main_osc_en      = (state_q != CM_STOP) && !ctrl_q[MOFF_BIT];
   assign sub_drive_strong = ctrl_q[DRV_BIT];
   assign main_tk          = main_tick && main_osc_en;

   cmc_phase_gen u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .main_tk    (main_tk),
      .sub_tk     (sub_tick),
      .want_sub   (ctrl_q[SEL_BIT]),
      .hold       (!running),
      .force_high (running && (stop_req || wait_req)),
      .phi        (cpu_clk),
      .sel_sub    (src_sub),
      .src_tick   (src_tick)
   );

   cmc_stab_timer #(
      .PRE_W(PRE_W), .S1_W(S1_W), .S2_W(S2_W),
      .S1_INIT(S1_INIT), .S2_INIT(S2_INIT)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (running && stop_req),
      .run   (state_q == CM_STAB),
      .tick  (src_tick),
      .done  (stab_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CM_RUN:  if (stop_req) state_d = CM_STOP;
                  else if (wait_req) state_d = CM_WAIT;
         CM_WAIT: if (wake) state_d = CM_RUN;
         CM_STOP: if (wake) state_d = CM_STAB;
         CM_STAB: if (stab_done) state_d = CM_RUN;
         default: state_d = CM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= CM_RUN;
      else        state_q <= state_d;
   end

   assign clk_held = !running;

   AST_HALT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      clk_held |-> cpu_clk); // R6
   AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (running && stop_req) |=> (!main_osc_en && clk_held && cpu_clk)); // R6
   AST_STOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (running && stop_req && wait_req) |=> (state_q == CM_STOP)); // R9
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CM_WAIT && !wake) |=> (state_q == CM_WAIT && cpu_clk)); // R8
   AST_WAIT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      (running && wait_req && !stop_req) |=> $stable(main_osc_en)); // R8
endmodule

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_tick = 1'b0, sub_tick = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [2:0] ctrl_wdata = 3'b001;
   logic       stop_req = 1'b0, wait_req = 1'b0;
   logic       irq_accept = 1'b0, irq_clkdep = 1'b0;
   logic       cpu_clk, clk_held, src_sub, main_osc_en, sub_drive_strong;
   int         checks = 0;
   int         failures = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   clk_mode_ctrl u_clk_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .stop_req(stop_req),
      .wait_req(wait_req), .irq_accept(irq_accept), .irq_clkdep(irq_clkdep),
      .cpu_clk(cpu_clk), .clk_held(clk_held), .src_sub(src_sub),
      .main_osc_en(main_osc_en), .sub_drive_strong(sub_drive_strong)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic s);
      main_tick = m; sub_tick = s;
      @(negedge clk);
      main_tick = 1'b0; sub_tick = 1'b0;
   endtask

   task automatic write_ctrl(input logic [2:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic irq(input logic dep);
      irq_accept = 1'b1; irq_clkdep = dep;
      @(negedge clk);
      irq_accept = 1'b0; irq_clkdep = 1'b0;
   endtask

   task automatic req(input logic stp, input logic wt);
      stop_req = stp; wait_req = wt;
      @(negedge clk);
      stop_req = 1'b0; wait_req = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "cpu_clk", cpu_clk, 1'b1);
      chk("R1", "clk_held", clk_held, 1'b0);
      chk("R1", "src_sub", src_sub, 1'b0);
      chk("R1", "main_osc_en", main_osc_en, 1'b1);
      chk("R1", "sub_drive_strong", sub_drive_strong, 1'b1);
   endtask

   task automatic t_normal();
      step(1'b0, 1'b1);
      chk("R2", "sub tick ignored", cpu_clk, 1'b1);
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1'b0);
         chk("R2", "toggle per main tick", cpu_clk, (i % 2 == 1));
      end
   endtask

   task automatic t_drive();
      write_ctrl(3'b000);
      chk("R5", "weak drive", sub_drive_strong, 1'b0);
      write_ctrl(3'b001);
      chk("R5", "strong drive", sub_drive_strong, 1'b1);
   endtask

   task automatic t_lowspeed();
      write_ctrl(3'b101);
      step(1'b0, 1'b0);
      chk("R3", "switch to sub while high", src_sub, 1'b1);
      write_ctrl(3'b111);
      chk("R4", "main osc off", main_osc_en, 1'b0);
      step(1'b1, 1'b0);
      chk("R3", "main tick ignored in low speed", cpu_clk, 1'b1);
      write_ctrl(3'b101);
      chk("R4", "main osc back on", main_osc_en, 1'b1);
      step(1'b0, 1'b1);
      chk("R3", "toggle per sub tick", cpu_clk, 1'b0);
      write_ctrl(3'b001);
      step(1'b0, 1'b0);
      chk("R3", "no switch while low", src_sub, 1'b1);
      step(1'b0, 1'b1);
      chk("R3", "sub tick raises clock", cpu_clk, 1'b1);
      step(1'b0, 1'b0);
      chk("R3", "switch back while high", src_sub, 1'b0);
      write_ctrl(3'b011);
      step(1'b1, 1'b0);
      chk("R4", "main tick discarded when main off", cpu_clk, 1'b1);
      write_ctrl(3'b001);
   endtask

   task automatic t_wait();
      step(1'b1, 1'b0);
      req(1'b0, 1'b1);
      chk("R8", "clock parked high", cpu_clk, 1'b1);
      chk("R8", "held flag", clk_held, 1'b1);
      chk("R8", "osc keeps running", main_osc_en, 1'b1);
      repeat (3) step(1'b1, 1'b0);
      chk("R8", "ticks ignored", cpu_clk, 1'b1);
      irq(1'b1);
      chk("R8", "clock-dependent irq ignored", clk_held, 1'b1);
      irq(1'b0);
      chk("R8", "external irq releases", clk_held, 1'b0);
      step(1'b1, 1'b0);
      chk("R8", "next tick toggles", cpu_clk, 1'b0);
      step(1'b1, 1'b0);
   endtask

   task automatic t_stop();
      bit bad = 1'b0;
      req(1'b1, 1'b0);
      chk("R6", "clock parked high", cpu_clk, 1'b1);
      chk("R6", "held flag", clk_held, 1'b1);
      chk("R6", "main osc stopped", main_osc_en, 1'b0);
      repeat (5) step(1'b1, 1'b0);
      irq(1'b1);
      chk("R6", "clock-dependent irq ignored", main_osc_en, 1'b0);
      chk("R6", "still held", clk_held, 1'b1);
      irq(1'b0);
      chk("R7", "osc restarted", main_osc_en, 1'b1);
      chk("R7", "held after wake", clk_held, 1'b1);
      for (int i = 0; i < 32767; i++) begin
         step(1'b1, 1'b0);
         if (clk_held !== 1'b1 || cpu_clk !== 1'b1) bad = 1'b1;
      end
      chk("R7", "held through 32767 ticks", bad, 1'b0);
      step(1'b1, 1'b0);
      chk("R7", "released at tick 32768", clk_held, 1'b0);
      step(1'b1, 1'b0);
      chk("R7", "clock runs after release", cpu_clk, 1'b0);
   endtask

   task automatic t_prio_reset();
      req(1'b1, 1'b1);
      chk("R9", "stop wins over wait", main_osc_en, 1'b0);
      do_reset();
      chk("R10", "reset leaves stop", clk_held, 1'b0);
      chk("R10", "reset clock level", cpu_clk, 1'b1);
      chk("R10", "reset osc enable", main_osc_en, 1'b1);
      req(1'b0, 1'b1);
      chk("R10", "in wait before reset", clk_held, 1'b1);
      do_reset();
      chk("R10", "reset leaves wait", clk_held, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal();
      t_drive();
      t_lowspeed();
      t_wait();
      t_stop();
      t_prio_reset();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule